// File: doc/BRIEF.md
# String Compare and Search Engine

This block is a multi-cycle engine that walks memory through a single read port and reports a Zero and a Carry flag. It has three operating modes. Compare mode reads two byte strings in lock-step and stops at a difference, at a zero byte or when the count runs out. Until mode scans forward from one pointer until an element equals a key. While mode scans forward as long as elements equal the key.

A client loads two address values, a count, a key, an element size and a mode, then pulses `start`. The engine issues reads with a request/valid handshake and never has more than one read outstanding. When it stops it pulses `done` for one cycle. At that point the updated pointers, the remaining count and the flags can be read on its outputs. The pointers, count and flags hold until the next accepted start.

Top module: `strscan_engine`

## Requirements
- R1: In compare mode (mode code 0) each step reads one byte at pointer A, then one byte at pointer B (`mem_size` = 0). After the second byte returns, both pointers increase by 1 and the count decreases by 1.
- R2: Compare mode stops after a step in which the count reaches zero, the two bytes differ, or the byte from pointer A is zero.
- R3: At completion, Zero is 1 when the last compared pair is equal. Carry is 1 when the first value is greater than or equal to the second as unsigned numbers. In compare mode the first value is the byte from A and the second is the byte from B. In the scan modes the first value is the key and the second is the element. The flags change only in the cycle `done` rises.
- R4: In until mode (mode code 1) each read decrements the count and advances pointer A by the element size. The scan stops when the element equals the key or the count reaches zero. Pointer B is unchanged.
- R5: In while mode (mode code 2) each read decrements the count. Pointer A advances by the element size only when the element equals the key. The scan stops at the first element that differs from the key or when the count reaches zero.
- R6: The element size codes are 0 for 8 bits, 1 for 16 bits and 2 for 32 bits; code 3 acts as 32 bits. The code is presented on `mem_size` (0, 1 or 2) for scan reads. The key and the read data are both cut to the element width before comparison, so upper bits of either have no effect. Compare reads use only `mem_rdata[7:0]`.
- R7: A start with count zero in any mode, or with mode code 3, performs no read. It pulses `done` in the next cycle, loads the pointer and count outputs from the inputs, and leaves both flags unchanged.
- R8: A new read is requested only after the previous read has returned `mem_rvalid`. `mem_req` is a one-cycle pulse and is never high while the engine is idle.
- R9: `done` is a one-cycle pulse in the cycle after the final `mem_rvalid`, with `busy` low. A `start` while `busy` is high is ignored.
- R10: After reset, `busy`, `done`, `mem_req`, both flags, both pointers and the count are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation when idle |
| mode | input | 2 | 0 compare, 1 until, 2 while, 3 no-op |
| elem_size | input | 2 | Scan element size code |
| ptr_a_i | input | ADDR_W | Initial pointer A |
| ptr_b_i | input | ADDR_W | Initial pointer B |
| count_i | input | CNT_W | Initial element count |
| key_i | input | DATA_W | Scan key |
| mem_req | output | 1 | Read request pulse |
| mem_addr | output | ADDR_W | Read byte address |
| mem_size | output | 2 | Read size code |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | DATA_W | Read data, element in the low bits |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Completion pulse |
| ptr_a_o | output | ADDR_W | Current pointer A |
| ptr_b_o | output | ADDR_W | Current pointer B |
| count_o | output | CNT_W | Remaining count |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |

## Verification
The properties assume a memory that asserts `mem_rvalid` only in answer to an earlier request, once for each request and at least one cycle later. They also assume that `mode` and `count_i` are valid in the cycle `start` is high.

The bench memory model meets this. It answers each request after a chosen latency of one to three cycles and fills the unused upper bytes of every response with a non-zero pattern. Inputs change only on falling edges, and the bench changes them again after start so that a design that did not capture them would be caught.

// File: rtl/strscan_pkg.sv
package strscan_pkg;

   typedef enum logic [1:0] {
      OP_CMP   = 2'd0,
      OP_UNTIL = 2'd1,
      OP_WHILE = 2'd2,
      OP_NONE  = 2'd3
   } scan_op_e;

   // Byte count of one element for a size code; code 3 falls back to four bytes.
   function automatic logic [2:0] elem_bytes(input logic [1:0] sz);
      case (sz)
         2'd0:    elem_bytes = 3'd1;
         2'd1:    elem_bytes = 3'd2;
         default: elem_bytes = 3'd4;
      endcase
   endfunction

endpackage

// File: rtl/strscan_lane_mask.sv
module strscan_lane_mask
   import strscan_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [1:0]        sz,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout
);
   localparam int LANES = DATA_W / 8;

   if (DATA_W % 8 != 0 || DATA_W < 32) begin : g_bad_width
      $error("strscan_lane_mask: DATA_W must be a multiple of 8 and at least 32");
   end

   logic [2:0] n_bytes;
   assign n_bytes = elem_bytes(sz);

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      if (g < 4) begin : g_live
         assign dout[g*8 +: 8] = (3'(g) < n_bytes) ? din[g*8 +: 8] : 8'h00;
      end else begin : g_dead
         assign dout[g*8 +: 8] = 8'h00;
      end
   end

endmodule

// File: rtl/strscan_order.sv
module strscan_order #(
   parameter int W = 32
) (
   input  logic [W-1:0] x,
   input  logic [W-1:0] y,
   output logic         eq,
   output logic         ge
);
   if (W < 1) begin : g_bad_width
      $error("strscan_order: W must be positive");
   end

   assign eq = (x == y);
   assign ge = (x >= y);

endmodule

// File: rtl/strscan_engine.sv
module strscan_engine
   import strscan_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int CNT_W  = 32,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [1:0]        mode,
   input  logic [1:0]        elem_size,
   input  logic [ADDR_W-1:0] ptr_a_i,
   input  logic [ADDR_W-1:0] ptr_b_i,
   input  logic [CNT_W-1:0]  count_i,
   input  logic [DATA_W-1:0] key_i,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [1:0]        mem_size,
   input  logic              mem_rvalid,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              busy,
   output logic              done,
   output logic [ADDR_W-1:0] ptr_a_o,
   output logic [ADDR_W-1:0] ptr_b_o,
   output logic [CNT_W-1:0]  count_o,
   output logic              flag_z,
   output logic              flag_c
);
   if (ADDR_W < 8 || CNT_W < 1) begin : g_bad_params
      $error("strscan_engine: ADDR_W must be at least 8 and CNT_W at least 1");
   end

   typedef enum logic [2:0] {
      S_IDLE, S_ISS_A, S_WAIT_A, S_ISS_B, S_WAIT_B
   } state_e;

   state_e             st_q;
   scan_op_e           op_q;
   logic [1:0]         sz_q;
   logic [DATA_W-1:0]  key_q;
   logic [ADDR_W-1:0]  pa_q, pb_q;
   logic [CNT_W-1:0]   cnt_q;
   logic [7:0]         byte_a_q;
   logic               zf_q, cf_q, done_q;

   logic [DATA_W-1:0]  key_m, elem_m;
   logic               scan_eq, scan_ge, byte_eq, byte_ge;
   logic [ADDR_W-1:0]  step;
   logic               last_cnt, scan_stop, cmp_stop;

   strscan_lane_mask #(.DATA_W(DATA_W)) u_key_mask (
      .sz(sz_q), .din(key_q), .dout(key_m));

   strscan_lane_mask #(.DATA_W(DATA_W)) u_data_mask (
      .sz(sz_q), .din(mem_rdata), .dout(elem_m));

   strscan_order #(.W(DATA_W)) u_scan_ord (
      .x(key_m), .y(elem_m), .eq(scan_eq), .ge(scan_ge));

   strscan_order #(.W(8)) u_byte_ord (
      .x(byte_a_q), .y(mem_rdata[7:0]), .eq(byte_eq), .ge(byte_ge));

   assign step      = ADDR_W'(elem_bytes(sz_q));
   assign last_cnt  = (cnt_q == CNT_W'(1));
   assign scan_stop = last_cnt || ((op_q == OP_UNTIL) ? scan_eq : !scan_eq);
   assign cmp_stop  = last_cnt || !byte_eq || (byte_a_q == 8'h00);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q     <= S_IDLE;
         op_q     <= OP_CMP;
         sz_q     <= 2'd0;
         key_q    <= '0;
         pa_q     <= '0;
         pb_q     <= '0;
         cnt_q    <= '0;
         byte_a_q <= 8'h00;
         zf_q     <= 1'b0;
         cf_q     <= 1'b0;
         done_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (st_q)
            S_IDLE: begin
               if (start) begin
                  op_q  <= scan_op_e'(mode);
                  sz_q  <= (elem_size == 2'd3) ? 2'd2 : elem_size;
                  key_q <= key_i;
                  pa_q  <= ptr_a_i;
                  pb_q  <= ptr_b_i;
                  cnt_q <= count_i;
                  if (count_i == '0 || scan_op_e'(mode) == OP_NONE) begin
                     done_q <= 1'b1;
                  end else begin
                     st_q <= S_ISS_A;
                  end
               end
            end
            S_ISS_A: st_q <= S_WAIT_A;
            S_WAIT_A: begin
               if (mem_rvalid) begin
                  if (op_q == OP_CMP) begin
                     byte_a_q <= mem_rdata[7:0];
                     st_q     <= S_ISS_B;
                  end else begin
                     cnt_q <= cnt_q - CNT_W'(1);
                     if (op_q == OP_UNTIL || scan_eq) begin
                        pa_q <= pa_q + step;
                     end
                     if (scan_stop) begin
                        zf_q   <= scan_eq;
                        cf_q   <= scan_ge;
                        done_q <= 1'b1;
                        st_q   <= S_IDLE;
                     end else begin
                        st_q <= S_ISS_A;
                     end
                  end
               end
            end
            S_ISS_B: st_q <= S_WAIT_B;
            S_WAIT_B: begin
               if (mem_rvalid) begin
                  pa_q  <= pa_q + ADDR_W'(1);
                  pb_q  <= pb_q + ADDR_W'(1);
                  cnt_q <= cnt_q - CNT_W'(1);
                  if (cmp_stop) begin
                     zf_q   <= byte_eq;
                     cf_q   <= byte_ge;
                     done_q <= 1'b1;
                     st_q   <= S_IDLE;
                  end else begin
                     st_q <= S_ISS_A;
                  end
               end
            end
            default: st_q <= S_IDLE;
         endcase
      end
   end

   assign mem_req  = (st_q == S_ISS_A) || (st_q == S_ISS_B);
   assign mem_addr = (st_q == S_ISS_B) ? pb_q : pa_q;
   assign mem_size = (op_q == OP_CMP) ? 2'd0 : sz_q;
   assign busy     = (st_q != S_IDLE);
   assign done     = done_q;
   assign ptr_a_o  = pa_q;
   assign ptr_b_o  = pb_q;
   assign count_o  = cnt_q;
   assign flag_z   = zf_q;
   assign flag_c   = cf_q;

endmodule

// File: rtl/strscan_engine_chk.sv
module strscan_engine_chk #(
   parameter int ADDR_W = 32,
   parameter int CNT_W  = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic [1:0]        mode,
   input logic [CNT_W-1:0]  count_i,
   input logic              mem_req,
   input logic [1:0]        mem_size,
   input logic              mem_rvalid,
   input logic              busy,
   input logic              done,
   input logic [ADDR_W-1:0] ptr_b_o,
   input logic [CNT_W-1:0]  count_o,
   input logic              flag_z,
   input logic              flag_c
);
   logic outst_q;
   logic op_cmp_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         outst_q  <= 1'b0;
         op_cmp_q <= 1'b0;
      end else begin
         if (mem_req)         outst_q <= 1'b1;
         else if (mem_rvalid) outst_q <= 1'b0;
         if (start && !busy)  op_cmp_q <= (mode == 2'd0);
      end
   end

   AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !outst_q); // R8
   AST_REQ_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_req); // R8
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy); // R9
   AST_CMP_BYTE_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && op_cmp_q) |-> (mem_size == 2'd0)); // R1
   AST_SIZE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (mem_size != 2'd3)); // R6
   AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(busy) && !$stable(count_o)) |-> (count_o == $past(count_o) - CNT_W'(1))); // R5
   AST_PTRB_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(busy) && !$stable(ptr_b_o)) |-> (ptr_b_o == $past(ptr_b_o) + ADDR_W'(1))); // R1
   AST_SCAN_PTRB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(busy) && !op_cmp_q) |-> $stable(ptr_b_o)); // R4
   AST_ZERO_COUNT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && count_i == '0) |=> (done && !busy)); // R7
   AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(flag_z) && $stable(flag_c))); // R3

endmodule

bind strscan_engine strscan_engine_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .count_i(count_i),
   .mem_req(mem_req), .mem_size(mem_size), .mem_rvalid(mem_rvalid),
   .busy(busy), .done(done), .ptr_b_o(ptr_b_o), .count_o(count_o),
   .flag_z(flag_z), .flag_c(flag_c));

// File: tb/strscan_engine_bench.sv
`timescale 1ns/1ps
module strscan_engine_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [1:0]  mode = 2'd0;
   logic [1:0]  elem_size = 2'd0;
   logic [31:0] ptr_a_i = '0, ptr_b_i = '0, count_i = '0, key_i = '0;
   logic        mem_req;
   logic [31:0] mem_addr;
   logic [1:0]  mem_size;
   logic        mem_rvalid = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic        busy, done;
   logic [31:0] ptr_a_o, ptr_b_o, count_o;
   logic        flag_z, flag_c;

   always #4 clk = ~clk;

   strscan_engine u_strscan_engine (
      .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .elem_size(elem_size),
      .ptr_a_i(ptr_a_i), .ptr_b_i(ptr_b_i), .count_i(count_i), .key_i(key_i),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_size(mem_size),
      .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
      .busy(busy), .done(done), .ptr_a_o(ptr_a_o), .ptr_b_o(ptr_b_o),
      .count_o(count_o), .flag_z(flag_z), .flag_c(flag_c));

   logic [7:0]  mem [0:255];
   logic [33:0] exp_q [$];
   int          n_checks = 0, n_errors = 0;
   int          lat = 1;
   int          pend = 0;
   logic [31:0] pend_data = '0;
   string       cur_req = "R1";
   logic        m_z = 1'b0, m_c = 1'b0;
   logic [31:0] e_pa, e_pb, e_cnt;
   int          total_cyc = 0;

   task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
      end
   endtask

   function automatic logic [31:0] rd(input logic [31:0] a, input logic [1:0] sz);
      logic [31:0] v;
      int nb;
      nb = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
      for (int i = 0; i < 4; i++)
         v[i*8 +: 8] = (i < nb) ? mem[(a + 32'(i)) & 32'hFF] : 8'hC3;
      return v;
   endfunction

   // Memory responder: answers each request after lat cycles.
   initial begin
      forever begin
         @(negedge clk);
         mem_rvalid = 1'b0;
         if (pend > 0) begin
            pend--;
            if (pend == 0) begin
               mem_rvalid = 1'b1;
               mem_rdata  = pend_data;
            end
         end
         if (mem_req) begin
            if (exp_q.size() == 0) begin
               chk(cur_req, "unexpected read", mem_addr, 32'hFFFF_FFFF);
            end else begin
               logic [33:0] e;
               e = exp_q.pop_front();
               chk(cur_req, "read address", mem_addr, e[31:0]);
               chk(cur_req, "read size", {30'd0, mem_size}, {30'd0, e[33:32]});
            end
            pend_data = rd(mem_addr, mem_size);
            pend = lat;
         end
      end
   end

   initial begin
      forever begin
         @(posedge clk);
         total_cyc++;
         if (total_cyc > 150000) begin
            n_checks++; n_errors++;
            $display("FAIL R9 watchdog: actual %0d expected below 150000", total_cyc);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
         end
      end
   end

   // Behavioural reference: final state plus the ordered list of reads.
   task automatic model(input int op, input int sz, input logic [31:0] pa, input logic [31:0] pb,
                        input logic [31:0] cnt, input logic [31:0] key);
      int nb;
      logic [1:0] szn;
      logic [31:0] mk, a, b, e, k;
      nb  = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
      szn = (sz == 3) ? 2'd2 : 2'(sz);
      mk  = (nb == 1) ? 32'hFF : (nb == 2) ? 32'hFFFF : 32'hFFFF_FFFF;
      exp_q.delete();
      if (cnt != 0 && op != 3) begin
         if (op == 0) begin
            forever begin
               a = {24'd0, mem[pa & 32'hFF]};
               b = {24'd0, mem[pb & 32'hFF]};
               exp_q.push_back({2'd0, pa});
               exp_q.push_back({2'd0, pb});
               pa++; pb++; cnt--;
               if (cnt == 0 || a != b || a == 0) break;
            end
            m_z = (a == b); m_c = (a >= b);
         end else begin
            k = key & mk;
            forever begin
               e = rd(pa, szn) & mk;
               exp_q.push_back({szn, pa});
               cnt--;
               if (op == 1 || e == k) pa += 32'(nb);
               if (cnt == 0 || (op == 1 ? (e == k) : (e != k))) break;
            end
            m_z = (k == e); m_c = (k >= e);
         end
      end
      e_pa = pa; e_pb = pb; e_cnt = cnt;
   endtask

   task automatic run(input string rq, input int op, input int sz, input logic [31:0] pa,
                      input logic [31:0] pb, input logic [31:0] cnt, input logic [31:0] key,
                      input int l, input bit disturb);
      int cyc;
      model(op, sz, pa, pb, cnt, key);
      lat = l; cur_req = rq;
      @(negedge clk);
      mode = 2'(op); elem_size = 2'(sz); ptr_a_i = pa; ptr_b_i = pb;
      count_i = cnt; key_i = key; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      ptr_a_i = 32'h5A5A_0000; ptr_b_i = 32'hA5A5_0000; count_i = 32'd9; key_i = 32'h1234_5678;
      cyc = 0;
      while (!done && cyc < 3000) begin
         if (disturb && cyc == 2) begin
            start = 1'b1; mode = 2'd3; count_i = 32'd0;
         end else begin
            start = 1'b0;
         end
         @(negedge clk);
         cyc++;
      end
      start = 1'b0;
      if (!done) begin
         n_checks++; n_errors++;
         $display("FAIL %s watchdog: actual no done expected done", rq);
      end
      if (cnt == 0 || op == 3) chk("R7", "done latency", 32'(cyc), 32'd0);
      chk(rq, "ptr_a", ptr_a_o, e_pa);
      chk(rq, "ptr_b", ptr_b_o, e_pb);
      chk(rq, "count", count_o, e_cnt);
      chk("R3", "flag_z", {31'd0, flag_z}, {31'd0, m_z});
      chk("R3", "flag_c", {31'd0, flag_c}, {31'd0, m_c});
      chk("R8", "reads left", 32'(exp_q.size()), 32'd0);
      chk("R9", "busy at done", {31'd0, busy}, 32'd0);
      @(negedge clk);
      chk("R9", "done pulse width", {31'd0, done}, 32'd0);
   endtask

   task automatic put(input int a, input logic [7:0] v);
      mem[a & 255] = v;
   endtask

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
      // strings for compare mode
      put(8'h10, "a"); put(8'h11, "b"); put(8'h12, "c"); put(8'h13, 0);
      put(8'h30, "a"); put(8'h31, "b"); put(8'h32, "c"); put(8'h33, 0);
      put(8'h40, "a"); put(8'h41, "b"); put(8'h42, "d");
      put(8'h50, "a"); put(8'h51, "b"); put(8'h52, "b");
      for (int i = 0; i < 4; i++) begin put(8'h60 + i, "x"); put(8'h70 + i, "x"); end
      // 16-bit halfwords
      put(8'h80, 8'h11); put(8'h81, 8'h11); put(8'h82, 8'h22); put(8'h83, 8'h22);
      put(8'h84, 8'h33); put(8'h85, 8'h33); put(8'h86, 8'h44); put(8'h87, 8'h44);
      // bytes
      put(8'h90, 1); put(8'h91, 2); put(8'h92, 3); put(8'h93, 4);
      // 32-bit words
      for (int w = 0; w < 2; w++) begin
         put(8'hA0 + 4*w, 8'hEF); put(8'hA1 + 4*w, 8'hBE); put(8'hA2 + 4*w, 8'hAD); put(8'hA3 + 4*w, 8'hDE);
      end
      put(8'hA8, 8'h10); put(8'hA9, 0); put(8'hAA, 0); put(8'hAB, 0);
      for (int i = 0; i < 3; i++) put(8'hB0 + i, 8'h7E);
      put(8'hC0, 8'h00); put(8'hC1, 8'h90);

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10", "busy", {31'd0, busy}, 32'd0);
      chk("R10", "done", {31'd0, done}, 32'd0);
      chk("R10", "mem_req", {31'd0, mem_req}, 32'd0);
      chk("R10", "flags", {30'd0, flag_z, flag_c}, 32'd0);
      chk("R10", "count", count_o, 32'd0);
      chk("R10", "ptr_a", ptr_a_o, 32'd0);

      run("R2", 0, 0, 32'h10, 32'h30, 32'd10, 32'd0, 1, 1'b0); // stop at terminator
      run("R2", 0, 0, 32'h40, 32'h50, 32'd10, 32'd0, 2, 1'b0); // differ, A greater
      run("R1", 0, 0, 32'h50, 32'h40, 32'd10, 32'd0, 1, 1'b0); // differ, A smaller
      run("R7", 0, 0, 32'h20, 32'h22, 32'd0,  32'd0, 1, 1'b0); // zero count compare
      run("R2", 0, 0, 32'h60, 32'h70, 32'd3,  32'd0, 3, 1'b0); // count exhausted
      run("R4", 1, 1, 32'h80, 32'h99, 32'd8,  32'hABCD_3333, 1, 1'b0); // until found, key upper bits
      run("R4", 1, 0, 32'h90, 32'h0,  32'd4,  32'h0000_0055, 2, 1'b0); // until not found
      run("R5", 2, 2, 32'hA0, 32'h0,  32'd5,  32'hDEAD_BEEF, 1, 1'b0); // while stops on mismatch
      run("R5", 2, 0, 32'hB0, 32'h0,  32'd3,  32'hFFFF_FF7E, 1, 1'b0); // while all match
      run("R5", 2, 1, 32'hC0, 32'h0,  32'd4,  32'h0000_1000, 3, 1'b0); // immediate mismatch
      run("R6", 1, 3, 32'hA0, 32'h0,  32'd4,  32'h0000_0010, 1, 1'b0); // size code 3 as 32-bit
      run("R7", 1, 2, 32'hA0, 32'h0,  32'd0,  32'hDEAD_BEEF, 1, 1'b0); // zero count scan
      run("R7", 3, 0, 32'h10, 32'h30, 32'd5,  32'd0, 1, 1'b0); // reserved mode
      run("R9", 0, 0, 32'h10, 32'h30, 32'd10, 32'd0, 3, 1'b1); // start while busy ignored

      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

endmodule